// File: doc/BRIEF.md
# Shared Interrupt Line Controller with Hold-off Timer

This block merges a vector of pulse-style interrupt events and a few GPIO edge events into one external interrupt pin. Each event sets a sticky pending bit. The pin becomes active whenever the master enable is on and at least one pending bit is also unmasked. Firmware clears a pending bit by writing a one to its position.

The pin can be driven in two ways. As a push-pull output, the output enable stays high and the active level can be chosen. As an open-drain output, the data stays low and the enable rises only while the line is active, so the wire can be shared with other devices. After the line drops, a programmable hold-off interval keeps it quiet before it may assert again. The interval is counted in ticks of `TICK_DIV` core clocks.

GPIO pins that are set up as interrupt inputs are synchronised first. Each one then raises its own pending bit on a rising or falling edge, chosen per pin.

Top module: `irq_line_ctrl`

## Requirements
- R1: The internal line register goes active one clock after the master enable is on and some pending bit is unmasked, with no hold-off running. It goes inactive one clock after that condition stops.
- R2: Pending bit i sets on the clock after `src_evt[i]` is high. It stays set until a clear write with `clr_mask[i]=1`. A set and a clear in the same cycle leave the bit set.
- R3: Register address 0 is the enable mask. Bit i enables pending bit i, and the GPIO sources sit at bits N_SRC+j. A pending bit whose mask bit is 0 does not activate the line.
- R4: Control bit 0 (address 1) is the master enable. While it is 0 the line stays inactive, but pending bits still latch. Setting it afterwards activates the line.
- R5: Push-pull mode is control bit 2 = 1. In this mode `irq_oe` is 1. `irq_o` equals control bit 1 while the line is active and its inverse while idle, so bit 1 = 1 means active high.
- R6: Open-drain mode is control bit 2 = 0. In this mode `irq_o` is always 0 and `irq_oe` is 1 only while the line is active.
- R7: Control bits 15:8 hold the hold-off interval. After the line goes inactive it stays inactive for interval×TICK_DIV clocks. With interval 0 the line can re-assert after a single inactive cycle.
- R8: Address 3 bit j enables GPIO pin j as an interrupt input. Address 2 bit j selects a rising edge (1) or a falling edge (0) for that pin. A qualifying edge sets pending bit N_SRC+j three clocks after the pin changes. A disabled pin, or an edge of the other direction, sets nothing.
- R9: After reset all registers and pending bits are 0. The block starts in open-drain, active-low mode with the master enable off, so `irq_o`=0 and `irq_oe`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select: 0 mask, 1 control, 2 GPIO edge polarity, 3 GPIO input enable |
| cfg_wdata | input | CFG_W | Register write data |
| src_evt | input | N_SRC | Interrupt event inputs, one per source |
| clr_we | input | 1 | Pending-clear strobe |
| clr_mask | input | N_SRC+N_GPIO | Write-one-to-clear mask for the pending bits |
| gpio_in | input | N_GPIO | Asynchronous GPIO pin levels |
| pend_o | output | N_SRC+N_GPIO | Pending status bits |
| irq_o | output | 1 | Interrupt pin data |
| irq_oe | output | 1 | Interrupt pin output enable |

## Verification
The main function is exercised with several patterns: a single enabled event, a masked event that is unmasked later, an event latched while the master enable is off, and a set and a clear arriving in the same cycle. Together these separate the roles of the mask, the master enable and the sticky status. The pin driver is tested in push-pull mode with both polarities and in open-drain mode, in both idle and active states, which shows whether the data and the enable are each driven correctly. Hold-off is measured cycle-exactly with a non-zero interval and with interval 0 by re-raising an event just as the line drops. GPIO edges are tried in the selected direction, in the opposite direction and on a disabled pin.

// File: rtl/irq_line_pkg.sv
package irq_line_pkg;

  typedef enum logic [1:0] {
    REG_MASK = 2'd0,
    REG_CTRL = 2'd1,
    REG_GPOL = 2'd2,
    REG_GEN  = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic [7:0] interval;
    logic       push_pull;
    logic       act_high;
    logic       master_en;
  } ctrl_t;

  // control word layout: [0] master, [1] active high, [2] push-pull, [15:8] interval
  function automatic ctrl_t decode_ctrl(input logic [15:0] w);
    ctrl_t c;
    c.master_en = w[0];
    c.act_high  = w[1];
    c.push_pull = w[2];
    c.interval  = w[15:8];
    return c;
  endfunction

  // returns {oe, data} for the pin
  function automatic logic [1:0] pin_drive(input logic active, input logic act_high,
                                           input logic push_pull);
    logic [1:0] r;
    if (push_pull) r = {1'b1, (active == act_high)};
    else           r = {active, 1'b0};
    return r;
  endfunction

  function automatic logic edge_hit(input logic cur, input logic prev, input logic rise_sel);
    return rise_sel ? (cur & ~prev) : (~cur & prev);
  endfunction

  function automatic int unsigned holdoff_cycles(input int unsigned interval,
                                                 input int unsigned div);
    return interval * div;
  endfunction

endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_line_pkg::*;
#(
  parameter int N_TOT  = 11,
  parameter int N_GPIO = 3,
  parameter int CFG_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [N_TOT-1:0]  mask_q,
  output ctrl_t             ctrl_q,
  output logic [N_GPIO-1:0] gpol_q,
  output logic [N_GPIO-1:0] gen_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      ctrl_q <= '0;
      gpol_q <= '0;
      gen_q  <= '0;
    end else if (cfg_we) begin
      unique case (reg_addr_e'(cfg_addr))
        REG_MASK: mask_q <= cfg_wdata[N_TOT-1:0];
        REG_CTRL: ctrl_q <= decode_ctrl(cfg_wdata[15:0]);
        REG_GPOL: gpol_q <= cfg_wdata[N_GPIO-1:0];
        REG_GEN:  gen_q  <= cfg_wdata[N_GPIO-1:0];
        default:  ;
      endcase
    end
  end

endmodule

// File: rtl/irq_gpio_edge.sv
module irq_gpio_edge
  import irq_line_pkg::*;
#(
  parameter int N_GPIO = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_GPIO-1:0] gpio_in,
  input  logic [N_GPIO-1:0] gpol,
  input  logic [N_GPIO-1:0] gen,
  output logic [N_GPIO-1:0] gpio_evt
);

  for (genvar g = 0; g < N_GPIO; g++) begin : g_pin
    logic s1, s2, prev;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        s1   <= 1'b0;
        s2   <= 1'b0;
        prev <= 1'b0;
      end else begin
        s1   <= gpio_in[g];
        s2   <= s1;
        prev <= s2;
      end
    end
    assign gpio_evt[g] = gen[g] & edge_hit(s2, prev, gpol[g]);
  end

endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int N_TOT = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_TOT-1:0] set_vec,
  input  logic             clr_we,
  input  logic [N_TOT-1:0] clr_mask,
  output logic [N_TOT-1:0] pend_q
);

  for (genvar i = 0; i < N_TOT; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)                  pend_q[i] <= 1'b0;
      else if (set_vec[i])         pend_q[i] <= 1'b1;
      else if (clr_we && clr_mask[i]) pend_q[i] <= 1'b0;
    end
  end

endmodule

// File: rtl/irq_holdoff.sv
module irq_holdoff #(
  parameter int TICK_DIV = 2000,
  parameter int IV_W     = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [IV_W-1:0] interval,
  output logic            busy
);

  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0] PMAX = PW'(TICK_DIV - 1);

  logic [IV_W-1:0] cnt_q;
  logic [PW-1:0]   presc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      presc_q <= '0;
    end else if (load) begin
      cnt_q   <= interval;
      presc_q <= '0;
    end else if (cnt_q != '0) begin
      if (presc_q == PMAX) begin
        presc_q <= '0;
        cnt_q   <= cnt_q - 1'b1;
      end else begin
        presc_q <= presc_q + 1'b1;
      end
    end
  end

  assign busy = (cnt_q != '0);

endmodule

// File: rtl/irq_line_ctrl.sv
module irq_line_ctrl
  import irq_line_pkg::*;
#(
  parameter int N_SRC    = 8,
  parameter int N_GPIO   = 3,
  parameter int CFG_W    = 16,
  parameter int TICK_DIV = 2000,
  localparam int N_TOT   = N_SRC + N_GPIO
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic [N_SRC-1:0]  src_evt,
  input  logic              clr_we,
  input  logic [N_TOT-1:0]  clr_mask,
  input  logic [N_GPIO-1:0] gpio_in,
  output logic [N_TOT-1:0]  pend_o,
  output logic              irq_o,
  output logic              irq_oe
);

  logic [N_TOT-1:0]  mask_q;
  ctrl_t             ctrl_q;
  logic [N_GPIO-1:0] gpol_q, gen_q, gpio_evt;
  logic              line_req, line_nxt, line_q, line_fall, holdoff_busy;
  logic              cfg_master, cfg_pp;
  logic [7:0]        cfg_interval;
  logic [1:0]        pin;

  irq_cfg_regs #(.N_TOT(N_TOT), .N_GPIO(N_GPIO), .CFG_W(CFG_W)) u_regs (
    .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata,
    .mask_q, .ctrl_q, .gpol_q, .gen_q
  );

  irq_gpio_edge #(.N_GPIO(N_GPIO)) u_gpio (
    .clk, .rst_n, .gpio_in, .gpol(gpol_q), .gen(gen_q), .gpio_evt
  );

  irq_pend_bank #(.N_TOT(N_TOT)) u_pend (
    .clk, .rst_n, .set_vec({gpio_evt, src_evt}), .clr_we, .clr_mask, .pend_q(pend_o)
  );

  assign cfg_master   = ctrl_q.master_en;
  assign cfg_pp       = ctrl_q.push_pull;
  assign cfg_interval = ctrl_q.interval;

  assign line_req  = cfg_master & |(pend_o & mask_q);
  assign line_nxt  = line_req & ~holdoff_busy;
  assign line_fall = line_q & ~line_nxt;

  always_ff @(posedge clk) begin
    if (!rst_n) line_q <= 1'b0;
    else        line_q <= line_nxt;
  end

  irq_holdoff #(.TICK_DIV(TICK_DIV), .IV_W(8)) u_hold (
    .clk, .rst_n, .load(line_fall), .interval(cfg_interval), .busy(holdoff_busy)
  );

  assign pin    = pin_drive(line_q, ctrl_q.act_high, cfg_pp);
  assign irq_oe = pin[1];
  assign irq_o  = pin[0];

endmodule

// File: rtl/irq_line_ctrl_chk.sv
module irq_line_ctrl_chk #(
  parameter int N_TOT = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_TOT-1:0] pend_o,
  input logic             clr_we,
  input logic [N_TOT-1:0] clr_mask,
  input logic             irq_o,
  input logic             irq_oe,
  input logic             line_q,
  input logic             line_fall,
  input logic             holdoff_busy,
  input logic             cfg_master,
  input logic             cfg_pp,
  input logic [7:0]       cfg_interval
);

  for (genvar i = 0; i < N_TOT; i++) begin : g_pend
    // R2
    pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pend_o[i]) |-> $past(clr_we && clr_mask[i]));
  end

  // R4
  master_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_q |-> $past(cfg_master));

  // R7
  holdoff_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    holdoff_busy |=> !line_q);

  // R7
  holdoff_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_fall && cfg_interval != 8'd0) |=> holdoff_busy);

  // R5
  pushpull_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_pp |-> irq_oe);

  // R6
  opendrain_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_pp |-> (!irq_o && (irq_oe == line_q)));

endmodule

bind irq_line_ctrl irq_line_ctrl_chk #(.N_TOT(N_TOT)) u_chk (
  .clk(clk), .rst_n(rst_n), .pend_o(pend_o), .clr_we(clr_we), .clr_mask(clr_mask),
  .irq_o(irq_o), .irq_oe(irq_oe), .line_q(line_q), .line_fall(line_fall),
  .holdoff_busy(holdoff_busy), .cfg_master(cfg_master), .cfg_pp(cfg_pp),
  .cfg_interval(cfg_interval)
);

// File: tb/irq_line_ctrl_tb.sv
`timescale 1ns/100ps
module irq_line_ctrl_tb;

  localparam int N_SRC = 8;
  localparam int N_GPIO = 3;
  localparam int N_TOT = N_SRC + N_GPIO;
  localparam int DIV = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic [N_SRC-1:0] src_evt = '0;
  logic clr_we = 1'b0;
  logic [N_TOT-1:0] clr_mask = '0;
  logic [N_GPIO-1:0] gpio_in = '0;
  logic [N_TOT-1:0] pend_o;
  logic irq_o, irq_oe;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irq_line_ctrl #(.N_SRC(N_SRC), .N_GPIO(N_GPIO), .CFG_W(16), .TICK_DIV(DIV)) u_dut (
    .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata, .src_evt, .clr_we, .clr_mask,
    .gpio_in, .pend_o, .irq_o, .irq_oe
  );

  // scoreboard: kind 0 = irq_o, 1 = irq_oe, 2 = pend_o
  typedef struct {
    string       tag;
    int          kind;
    logic [31:0] exp;
  } item_t;
  item_t sb_q[$];

  initial begin
    forever begin
      wait (sb_q.size() != 0);
      begin
        item_t it;
        logic [31:0] act;
        it = sb_q.pop_front();
        case (it.kind)
          0: act = 32'(irq_o);
          1: act = 32'(irq_oe);
          default: act = 32'(pend_o);
        endcase
        n_tests++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s: actual %0h expected %0h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic expect_val(input string tag, input int kind, input logic [31:0] exp);
    sb_q.push_back('{tag, kind, exp});
    wait (sb_q.size() == 0);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    step(1);
    cfg_we = 1'b0;
  endtask

  task automatic pulse(input logic [N_SRC-1:0] v);
    src_evt = v;
    step(1);
    src_evt = '0;
  endtask

  task automatic clr(input logic [N_TOT-1:0] m);
    clr_we = 1'b1; clr_mask = m;
    step(1);
    clr_we = 1'b0; clr_mask = '0;
  endtask

  initial begin
    step(3);
    // R9 reset state
    expect_val("R9 irq_o", 0, 0);
    expect_val("R9 irq_oe", 1, 0);
    expect_val("R9 pend", 2, 0);
    rst_n = 1'b1;
    step(1);

    wr(2'd0, 16'h07FF);
    wr(2'd1, 16'h0007);
    expect_val("R5 idle pushpull oe", 1, 1);
    expect_val("R5 idle high-active level", 0, 0);

    pulse(8'h04);
    expect_val("R2 pend set", 2, 32'h004);
    expect_val("R1 one-cycle latency", 0, 0);
    step(1);
    expect_val("R1 line active", 0, 1);
    clr(11'h004);
    expect_val("R2 cleared", 2, 0);
    step(1);
    expect_val("R1 line drops", 0, 0);

    // R3 mask
    wr(2'd0, 16'h07F7);
    pulse(8'h08);
    step(2);
    expect_val("R3 masked pend latched", 2, 32'h008);
    expect_val("R3 masked line idle", 0, 0);
    wr(2'd0, 16'h07FF);
    step(1);
    expect_val("R3 unmasked line active", 0, 1);

    // R5 active low
    wr(2'd1, 16'h0005);
    expect_val("R5 active-low active level", 0, 0);
    clr(11'h008);
    step(1);
    expect_val("R5 active-low idle level", 0, 1);

    // R6 open drain
    wr(2'd1, 16'h0001);
    expect_val("R6 od idle oe", 1, 0);
    expect_val("R6 od idle data", 0, 0);
    pulse(8'h01);
    step(1);
    expect_val("R6 od active oe", 1, 1);
    expect_val("R6 od active data", 0, 0);
    clr(11'h001);
    step(1);
    expect_val("R6 od released", 1, 0);

    // R4 master enable
    wr(2'd1, 16'h0006);
    pulse(8'h20);
    step(2);
    expect_val("R4 pend latches with master off", 2, 32'h020);
    expect_val("R4 line idle with master off", 0, 0);
    wr(2'd1, 16'h0007);
    step(1);
    expect_val("R4 line after master on", 0, 1);
    clr(11'h020);
    step(1);

    // R7 hold-off interval 3 -> 12 cycles
    wr(2'd1, 16'h0307);
    pulse(8'h02);
    step(1);
    expect_val("R7 line active before holdoff", 0, 1);
    clr(11'h002);
    pulse(8'h02);
    step(12);
    expect_val("R7 still held off", 0, 0);
    step(1);
    expect_val("R7 reasserts after interval", 0, 1);
    clr(11'h002);
    step(1);
    wr(2'd1, 16'h0007);
    step(16);

    // R7 interval zero
    pulse(8'h02);
    step(1);
    expect_val("R7 zero active", 0, 1);
    clr(11'h002);
    pulse(8'h02);
    expect_val("R7 zero one low cycle", 0, 0);
    step(1);
    expect_val("R7 zero reasserts", 0, 1);

    // R2 set beats clear
    clr_we = 1'b1; clr_mask = 11'h002; src_evt = 8'h02;
    step(1);
    clr_we = 1'b0; clr_mask = '0; src_evt = '0;
    expect_val("R2 set wins over clear", 2, 32'h002);
    clr(11'h002);
    step(2);

    // R8 GPIO edges
    wr(2'd2, 16'h0001);
    wr(2'd3, 16'h0003);
    gpio_in[0] = 1'b1;
    step(2);
    expect_val("R8 rising not yet", 2, 0);
    step(1);
    expect_val("R8 rising sets bit 8", 2, 32'h100);
    clr(11'h100);
    gpio_in[1] = 1'b1;
    step(4);
    expect_val("R8 wrong direction ignored", 2, 0);
    gpio_in[1] = 1'b0;
    step(3);
    expect_val("R8 falling sets bit 9", 2, 32'h200);
    clr(11'h200);
    gpio_in[2] = 1'b1;
    step(4);
    gpio_in[2] = 1'b0;
    step(4);
    expect_val("R8 disabled pin ignored", 2, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule